// File: doc/BRIEF.md
# Dual Synthesizer Power Control

This block decides, once per clock, whether each of two synthesizer channels (RF and IF) is powered up or down. It takes two external enable pins and the per-channel power-down bits from the serial control register. From the result it drives the enables of each channel's N and R counters and the high-impedance controls for each channel's charge pump and phase comparator. It also controls the shared reference oscillator, both its enable and the high-impedance state of its pin.

The enable pins have priority. A low pin forces its channel down. When only one pin is high, that channel runs whatever its register bit says. Only when both pins are high do the register bits decide. The oscillator stops only when both channels are down, and a keep-oscillator-alive register bit holds it running regardless of the pins. When a channel comes out of power-down, a one-cycle counter-clear pulse goes out with the first enabled cycle, so its N and R counters restart together from zero. An external counter-reset request clears the counters of both channels. Every output comes from a register, so the enables cannot glitch.

Top module: `dual_pll_pwr_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four counter enables are 0, both counter clears are 0, all four tri-state controls are 1, the oscillator enable is 0 and the oscillator pin high-impedance control is 1.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. A channel whose enable pin is low is down in the next cycle, whatever its power-down bit is.
- R3: When a channel's enable pin is high and the other channel's pin is low, that channel is up, whatever its power-down bit is.
- R4: When both enable pins are high, a channel is up when its power-down bit is 0 and down when it is 1.
- R5: For an up channel, its N and R counter enables are 1 and its charge-pump and phase-comparator tri-state controls are 0. For a down channel, each of these four outputs takes the opposite value.
- R6: The oscillator enable is 0 and the oscillator pin high-impedance control is 1 exactly when both channels are down and the keep-oscillator-alive bit is 0. Otherwise the enable is 1 and the high-impedance control is 0.
- R7: With the keep-oscillator-alive bit at 1, the oscillator stays enabled even when both enable pins are low.
- R8: In the first cycle in which a channel's counter enables go to 1 after being 0, that channel's counter clear is 1 for exactly that cycle, unless a reset request keeps it high.
- R9: A counter-reset request sampled at an edge sets the counter clear of both channels to 1 in the next cycle, whether or not the channels are powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rf_en_pin | input | 1 | RF channel enable pin |
| if_en_pin | input | 1 | IF channel enable pin |
| rf_pd_bit | input | 1 | RF power-down register bit (1 = down) |
| if_pd_bit | input | 1 | IF power-down register bit (1 = down) |
| osc_keep_bit | input | 1 | Keep reference oscillator running |
| cnt_rst_req | input | 1 | Request to clear both channels' counters |
| rf_n_cnt_en | output | 1 | RF N counter enable |
| rf_r_cnt_en | output | 1 | RF R counter enable |
| rf_cnt_clr | output | 1 | RF counter clear |
| rf_cp_hiz | output | 1 | RF charge pump tri-state |
| rf_pfd_hiz | output | 1 | RF phase comparator tri-state |
| if_n_cnt_en | output | 1 | IF N counter enable |
| if_r_cnt_en | output | 1 | IF R counter enable |
| if_cnt_clr | output | 1 | IF counter clear |
| if_cp_hiz | output | 1 | IF charge pump tri-state |
| if_pfd_hiz | output | 1 | IF phase comparator tri-state |
| osc_en | output | 1 | Reference oscillator enable |
| osc_pin_hiz | output | 1 | Oscillator pin high-impedance control |

## Verification
The hardest case to reach is one where a single input change switches which precedence rule applies. An example is one pin dropping while the other channel's power-down bit is set. The drop brings that other channel up through the one-pin rule and must raise its clear pulse. Random stimulus keeps the pins mostly high and toggles every input each cycle, so these edges between rules come up often. Directed steps add the keep-alive case with both pins low, and a reset request that lands in the same cycle as a power-up.

// File: rtl/pwr_ctl_pkg.sv
// Shared definitions for the dual synthesizer power control.
// Assumes a fixed pair of channels, indexed by the constants below.
package pwr_ctl_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_RF  = 0;
    localparam int CH_IF  = 1;

    // Registered control bundle driven to one channel.
    typedef struct packed {
        logic n_en;
        logic r_en;
        logic clr;
        logic cp_hiz;
        logic pfd_hiz;
    } ch_ctl_t;

    localparam ch_ctl_t CH_CTL_OFF = '{n_en: 1'b0, r_en: 1'b0, clr: 1'b0,
                                       cp_hiz: 1'b1, pfd_hiz: 1'b1};
endpackage

// File: rtl/pwr_ch_resolve.sv
// Decides, without registers, which channels should be powered up.
// A low pin forces its channel down. With every pin high, the register
// bits decide. Otherwise a high pin alone keeps its channel up.
module pwr_ch_resolve #(
    parameter int N_CH = 2
) (
    input  logic [N_CH-1:0] en_pin,
    input  logic [N_CH-1:0] pd_bit,
    output logic [N_CH-1:0] up_nxt
);
    logic all_pins_hi;

    // Register bits apply only when every pin is high.
    always_comb all_pins_hi = &en_pin;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        // Per-channel precedence: pin first, then the register bit.
        always_comb up_nxt[g] = all_pins_hi ? ~pd_bit[g] : en_pin[g];
    end
endmodule

// File: rtl/pwr_ch_seq.sv
// Registers the control bundle of one channel and makes the counter-clear
// pulse on power-up. Assumes up_nxt is a settled combinational decision.
module pwr_ch_seq
    import pwr_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    up_nxt,
    input  logic    clr_req,
    output ch_ctl_t ctl
);
    logic rising;

    // Power-up edge, seen against the enable currently driven.
    always_comb rising = up_nxt & ~ctl.n_en;

    // Registers every control, so the outputs cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= CH_CTL_OFF;
        end else begin
            ctl.n_en    <= up_nxt;
            ctl.r_en    <= up_nxt;
            ctl.clr     <= rising | clr_req;
            ctl.cp_hiz  <= ~up_nxt;
            ctl.pfd_hiz <= ~up_nxt;
        end
    end
endmodule

// File: rtl/pwr_osc_ctl.sv
// Registered control of the shared reference oscillator. It runs while
// any channel is up or the keep-alive bit is set.
module pwr_osc_ctl #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] up_nxt,
    input  logic            keep,
    output logic            osc_en,
    output logic            pin_hiz
);
    logic run_nxt;

    // Run request: any channel up, or held on by the keep bit.
    always_comb run_nxt = (|up_nxt) | keep;

    // Registered oscillator enable and pin state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_en  <= 1'b0;
            pin_hiz <= 1'b1;
        end else begin
            osc_en  <= run_nxt;
            pin_hiz <= ~run_nxt;
        end
    end
endmodule

// File: rtl/dual_pll_pwr_ctl.sv
// Top of the dual synthesizer power control. It gathers the pins and
// register bits into vectors, resolves the power state and registers the
// per-channel and oscillator controls. One cycle of latency on all outputs.
module dual_pll_pwr_ctl
    import pwr_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rf_en_pin,
    input  logic if_en_pin,
    input  logic rf_pd_bit,
    input  logic if_pd_bit,
    input  logic osc_keep_bit,
    input  logic cnt_rst_req,
    output logic rf_n_cnt_en,
    output logic rf_r_cnt_en,
    output logic rf_cnt_clr,
    output logic rf_cp_hiz,
    output logic rf_pfd_hiz,
    output logic if_n_cnt_en,
    output logic if_r_cnt_en,
    output logic if_cnt_clr,
    output logic if_cp_hiz,
    output logic if_pfd_hiz,
    output logic osc_en,
    output logic osc_pin_hiz
);
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] pd_vec;
    logic [NUM_CH-1:0] up_nxt;
    ch_ctl_t           ctl [NUM_CH];

    // Packs the pins and bits into channel-indexed vectors.
    always_comb begin
        en_vec[CH_RF] = rf_en_pin;
        en_vec[CH_IF] = if_en_pin;
        pd_vec[CH_RF] = rf_pd_bit;
        pd_vec[CH_IF] = if_pd_bit;
    end

    pwr_ch_resolve #(.N_CH(NUM_CH)) u_resolve (
        .en_pin (en_vec),
        .pd_bit (pd_vec),
        .up_nxt (up_nxt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_seq
        pwr_ch_seq u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_nxt  (up_nxt[g]),
            .clr_req (cnt_rst_req),
            .ctl     (ctl[g])
        );
    end

    pwr_osc_ctl #(.N_CH(NUM_CH)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_nxt  (up_nxt),
        .keep    (osc_keep_bit),
        .osc_en  (osc_en),
        .pin_hiz (osc_pin_hiz)
    );

    // Unpacks the channel bundles onto the named ports.
    always_comb begin
        rf_n_cnt_en = ctl[CH_RF].n_en;
        rf_r_cnt_en = ctl[CH_RF].r_en;
        rf_cnt_clr  = ctl[CH_RF].clr;
        rf_cp_hiz   = ctl[CH_RF].cp_hiz;
        rf_pfd_hiz  = ctl[CH_RF].pfd_hiz;
        if_n_cnt_en = ctl[CH_IF].n_en;
        if_r_cnt_en = ctl[CH_IF].r_en;
        if_cnt_clr  = ctl[CH_IF].clr;
        if_cp_hiz   = ctl[CH_IF].cp_hiz;
        if_pfd_hiz  = ctl[CH_IF].pfd_hiz;
    end
endmodule

// File: rtl/dual_pll_pwr_chk.sv
// Port-level checks of the power control, bound to the top module.
module dual_pll_pwr_chk (
    input logic clk,
    input logic rst_n,
    input logic rf_en_pin,
    input logic if_en_pin,
    input logic rf_pd_bit,
    input logic if_pd_bit,
    input logic osc_keep_bit,
    input logic cnt_rst_req,
    input logic rf_n_cnt_en,
    input logic rf_r_cnt_en,
    input logic rf_cnt_clr,
    input logic rf_cp_hiz,
    input logic rf_pfd_hiz,
    input logic if_n_cnt_en,
    input logic if_r_cnt_en,
    input logic if_cnt_clr,
    input logic if_cp_hiz,
    input logic if_pfd_hiz,
    input logic osc_en,
    input logic osc_pin_hiz
);
    AST_RF_PIN_LOW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_en_pin |=> (!rf_n_cnt_en && !rf_r_cnt_en));   // R2
    AST_IF_PIN_LOW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en_pin |=> (!if_n_cnt_en && !if_r_cnt_en));   // R2
    AST_RF_SOLE_PIN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en_pin && !if_en_pin) |=> rf_n_cnt_en);       // R3
    AST_BOTH_PINS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en_pin && if_en_pin && if_pd_bit) |=> (if_cp_hiz && if_pfd_hiz)); // R4
    AST_RF_HIZ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_r_cnt_en |-> (rf_cp_hiz && rf_pfd_hiz));      // R5
    AST_OSC_OFF_BOTH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        osc_pin_hiz |-> (!rf_n_cnt_en && !if_n_cnt_en && !osc_en)); // R6
    AST_OSC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        osc_keep_bit |=> (osc_en && !osc_pin_hiz));       // R7
    AST_RF_POWERUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_n_cnt_en) |-> rf_cnt_clr);               // R8
    AST_IF_POWERUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_n_cnt_en) |-> if_cnt_clr);               // R8
    AST_RST_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_req |=> (rf_cnt_clr && if_cnt_clr));      // R9
endmodule

bind dual_pll_pwr_ctl dual_pll_pwr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rf_en_pin(rf_en_pin), .if_en_pin(if_en_pin),
    .rf_pd_bit(rf_pd_bit), .if_pd_bit(if_pd_bit), .osc_keep_bit(osc_keep_bit),
    .cnt_rst_req(cnt_rst_req), .rf_n_cnt_en(rf_n_cnt_en), .rf_r_cnt_en(rf_r_cnt_en),
    .rf_cnt_clr(rf_cnt_clr), .rf_cp_hiz(rf_cp_hiz), .rf_pfd_hiz(rf_pfd_hiz),
    .if_n_cnt_en(if_n_cnt_en), .if_r_cnt_en(if_r_cnt_en), .if_cnt_clr(if_cnt_clr),
    .if_cp_hiz(if_cp_hiz), .if_pfd_hiz(if_pfd_hiz), .osc_en(osc_en),
    .osc_pin_hiz(osc_pin_hiz)
);

// File: tb/tb_dual_pll_pwr_ctl.sv
// Bench: fixed-seed random stimulus plus directed corner cases, compared
// against a behavioural model written from the requirements.
module tb_dual_pll_pwr_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rf_en_pin = 1'b0, if_en_pin = 1'b0, rf_pd_bit = 1'b0, if_pd_bit = 1'b0;
    logic osc_keep_bit = 1'b0, cnt_rst_req = 1'b0;
    logic rf_n_cnt_en, rf_r_cnt_en, rf_cnt_clr, rf_cp_hiz, rf_pfd_hiz;
    logic if_n_cnt_en, if_r_cnt_en, if_cnt_clr, if_cp_hiz, if_pfd_hiz;
    logic osc_en, osc_pin_hiz;

    int n_chk = 0;
    int n_fail = 0;
    logic prev_rf_up = 1'b0;
    logic prev_if_up = 1'b0;

    always #5 clk = ~clk;

    dual_pll_pwr_ctl dut (.*);

    // Channel state from pins and bits: pin precedence, then bits (R2-R4).
    function automatic logic model_up(input logic own_pin, input logic other_pin,
                                      input logic own_pd);
        return (own_pin && other_pin) ? ~own_pd : own_pin;
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string pin_tag(input logic own_pin, input logic other_pin);
        if (!own_pin) return "R2";
        if (!other_pin) return "R3";
        return "R4";
    endfunction

    // Applies one input set at a falling edge, checks it one cycle later.
    task automatic step(input logic rp, input logic ip, input logic rpd,
                        input logic ipd, input logic keep, input logic req);
        logic ru, iu;
        rf_en_pin = rp; if_en_pin = ip; rf_pd_bit = rpd; if_pd_bit = ipd;
        osc_keep_bit = keep; cnt_rst_req = req;
        ru = model_up(rp, ip, rpd);
        iu = model_up(ip, rp, ipd);
        @(negedge clk);
        chk({pin_tag(rp, ip), " rf enables"}, {3'b0, rf_n_cnt_en, rf_r_cnt_en}, {3'b0, ru, ru});
        chk({pin_tag(ip, rp), " if enables"}, {3'b0, if_n_cnt_en, if_r_cnt_en}, {3'b0, iu, iu});
        chk("R5 tri-states", {1'b0, rf_cp_hiz, rf_pfd_hiz, if_cp_hiz, if_pfd_hiz},
            {1'b0, ~ru, ~ru, ~iu, ~iu});
        chk(keep ? "R7 osc keep" : "R6 osc", {3'b0, osc_en, osc_pin_hiz},
            {3'b0, ru | iu | keep, ~(ru | iu | keep)});
        chk(req ? "R9 clear request" : "R8 power-up clear", {3'b0, rf_cnt_clr, if_cnt_clr},
            {3'b0, req | (ru & ~prev_rf_up), req | (iu & ~prev_if_up)});
        prev_rf_up = ru;
        prev_if_up = iu;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: outputs while reset is asserted.
        chk("R1 reset", {rf_n_cnt_en, rf_r_cnt_en, rf_cnt_clr, rf_cp_hiz, rf_pfd_hiz}, 5'b00011);
        chk("R1 reset", {if_n_cnt_en, if_r_cnt_en, if_cnt_clr, if_cp_hiz, if_pfd_hiz}, 5'b00011);
        chk("R1 reset osc", {3'b0, osc_en, osc_pin_hiz}, 5'b00001);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);                 // R1: stays off after release
        // Directed corner cases.
        step(0, 0, 0, 0, 1, 0);                 // R7: keep alive, both pins low
        step(1, 1, 0, 1, 0, 0);                 // R4/R8: RF up through bits
        step(1, 0, 0, 1, 0, 0);                 // R3: RF holds via pin
        step(1, 1, 1, 1, 0, 0);                 // R4: both down by bits
        step(1, 0, 1, 0, 0, 1);                 // R3/R8/R9: power-up with request
        step(0, 1, 1, 1, 0, 0);                 // R2/R3: IF up despite bit
        step(0, 0, 0, 0, 0, 1);                 // R9: request while both down
        step(0, 0, 0, 0, 0, 0);                 // R6: oscillator off
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % 2,
                 $urandom % 2, ($urandom % 4) == 0, ($urandom % 8) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule